// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial port driven from the system clock. A programmable divisor produces a tick at sixteen times the bit rate. The transmitter turns a byte written over a simple strobe-and-data port into a frame: a low start bit, 5 to 8 data bits sent least-significant bit first, an optional parity bit and a stop period of 1, 1.5 or 2 bit times. The line idles high.

The receiver watches the line on every tick. It confirms a start edge at mid-bit and throws away glitches that are too short to be a start bit. It then samples each following bit at its centre, checks parity and the first stop bit, and recognises a line break. The finished character and its status flags are held until the next character replaces them. A read strobe clears the valid flag.

The transmitter can hold the line low to send a break. A loopback switch feeds the transmitter's line straight into the receiver and keeps the external output pin high.

Top module: `serial_xcvr`

## Requirements
- R1: The serial output idles high. A frame is a low start bit, then the data bits least-significant bit first, then the optional parity bit, then the stop period at high level.
- R2: `tx_ready` is high when the transmitter is idle. A write with `tx_wr` high while `tx_ready` is high is accepted, and `tx_ready` is low from the next cycle until the stop period ends.
- R3: `char_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The receiver returns the character right-aligned, with the unused upper bits at zero.
- R4: When `par_en` is 1 the transmitter sends one parity bit after the data. With `par_even`=1 the parity bit makes the count of ones in data plus parity even; with `par_even`=0 it makes that count odd. The receiver raises `parity_err` with a character whose parity bit does not match.
- R5: `stop_sel` sets the transmit stop period: 0 gives 16 ticks, 1 gives 24 ticks, 2 or 3 give 32 ticks. The receiver checks only the first stop bit.
- R6: One oversample tick occurs every max(`divisor`,1) clock cycles, and a bit lasts 16 ticks.
- R7: While `loopback` is 1, `txd` stays high and the receiver takes its input from the transmitter's internal line instead of `rxd`.
- R8: A low level on the receive line that is high again when the start bit is sampled at its centre produces no character.
- R9: While `send_break` is 1 the transmitter's line is held low. When the receiver gets a character whose data, parity and first stop bit are all low, it delivers data 0 with `break_det` and `frame_err` set and `parity_err` clear. It then waits for the line to go high before it accepts another start bit.
- R10: A character whose first stop bit is sampled low has `frame_err` set.
- R11: `rx_valid` rises when a character completes and falls the cycle after `rx_rd` is high. `rx_data` and the three error flags stay valid until the next character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Clock cycles per oversample tick (0 acts as 1) |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel | input | 2 | Transmit stop period select |
| loopback | input | 1 | Route transmit line to receiver, hold `txd` high |
| send_break | input | 1 | Force the transmit line low |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Transmitter idle, write accepted |
| rx_rd | input | 1 | Read strobe, clears `rx_valid` |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | Unread character present |
| parity_err | output | 1 | Parity mismatch on last character |
| frame_err | output | 1 | First stop bit low on last character |
| break_det | output | 1 | Last character was a line break |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The properties assume that the format inputs (`char_len`, parity and stop selects, `divisor`) stay fixed while a frame is in flight. The stimulus changes them only when the transmitter is idle and the receive line has been high for at least a bit time. The break and loopback properties treat `send_break` and `loopback` as plain levels with no handshake. The bench drives received frames with bit times that are exact multiples of the tick period, so the receiver's centre sampling keeps about half a bit of margin on each side. The glitch used for the false-start case is kept well under half a bit long.

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       char_len,
  input  logic             par_en,
  input  logic             par_even,
  input  logic [1:0]       stop_sel,
  input  logic             loopback,
  input  logic             send_break,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             parity_err,
  output logic             frame_err,
  output logic             break_det,
  input  logic             rxd,
  output logic             txd
);

  localparam int OVS      = 16;
  localparam int SUB_W    = 6;
  localparam int RSUB_W   = $clog2(OVS);
  localparam logic [RSUB_W-1:0] MID  = RSUB_W'(OVS/2 - 1);
  localparam logic [RSUB_W-1:0] LAST = RSUB_W'(OVS - 1);

  // oversample tick
  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  assign tick = (div_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= (divisor == '0) ? '0 : divisor - 1'b1;
    else           div_cnt <= div_cnt - 1'b1;
  end

  // frame format
  logic [3:0]       nbits;
  logic [7:0]       len_mask;
  logic [SUB_W-1:0] stop_last;
  assign nbits     = 4'd5 + {2'b00, char_len};
  assign len_mask  = 8'hFF >> (4'd8 - nbits);
  assign stop_last = stop_sel[1] ? SUB_W'(OVS*2 - 1)
                   : stop_sel[0] ? SUB_W'(OVS*3/2 - 1) : SUB_W'(OVS - 1);

  // transmitter
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
  tx_st_t           tx_st;
  logic [SUB_W-1:0] tx_sub;
  logic [3:0]       tx_cnt;
  logic [7:0]       tx_sh;
  logic             tx_par;
  logic             tx_bit_end;
  logic             tx_line;

  assign tx_bit_end = tick && (tx_sub == ((tx_st == T_STOP) ? stop_last : SUB_W'(OVS - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st  <= T_IDLE;
      tx_sub <= '0;
      tx_cnt <= '0;
      tx_sh  <= '0;
      tx_par <= 1'b0;
    end else if (tx_st == T_IDLE) begin
      if (tx_wr) begin
        tx_sh  <= tx_data;
        tx_par <= (^(tx_data & len_mask)) ^ !par_even;
        tx_sub <= '0;
        tx_st  <= T_START;
      end
    end else if (tick) begin
      if (!tx_bit_end) tx_sub <= tx_sub + 1'b1;
      else begin
        tx_sub <= '0;
        case (tx_st)
          T_START: begin
            tx_cnt <= '0;
            tx_st  <= T_DATA;
          end
          T_DATA: begin
            tx_sh  <= tx_sh >> 1;
            tx_cnt <= tx_cnt + 1'b1;
            if (tx_cnt == nbits - 4'd1) tx_st <= par_en ? T_PAR : T_STOP;
          end
          T_PAR:   tx_st <= T_STOP;
          default: tx_st <= T_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (tx_st)
      T_START: tx_line = 1'b0;
      T_DATA:  tx_line = tx_sh[0];
      T_PAR:   tx_line = tx_par;
      default: tx_line = 1'b1;
    endcase
    if (send_break) tx_line = 1'b0;
  end

  assign tx_ready = (tx_st == T_IDLE);
  assign txd      = loopback | tx_line;

  // receiver input
  logic [1:0] rx_sync;
  logic       rx_s;
  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], loopback ? tx_line : rxd};
  end
  assign rx_s = rx_sync[1];

  // receiver
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;
  rx_st_t            rx_st;
  logic [RSUB_W-1:0] rx_sub;
  logic [3:0]        rx_cnt;
  logic [7:0]        rx_sh;
  logic              rx_pbit;
  logic              rx_zero;
  logic [7:0]        rx_aligned;
  logic              rx_brk;
  logic              rx_centre;

  assign rx_aligned = rx_sh >> (4'd8 - nbits);
  assign rx_brk     = rx_zero && !rx_s;
  assign rx_centre  = tick && (rx_sub == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st      <= R_IDLE;
      rx_sub     <= '0;
      rx_cnt     <= '0;
      rx_sh      <= '0;
      rx_pbit    <= 1'b0;
      rx_zero    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_det  <= 1'b0;
    end else begin
      if (rx_rd) rx_valid <= 1'b0;
      if (tick && rx_st != R_IDLE && rx_st != R_HOLD) rx_sub <= rx_sub + 1'b1;
      case (rx_st)
        R_IDLE: if (tick && !rx_s) begin
          rx_sub <= '0;
          rx_st  <= R_START;
        end
        R_START: if (tick && rx_sub == MID) begin
          rx_sub  <= '0;
          rx_cnt  <= '0;
          rx_sh   <= '0;
          rx_zero <= 1'b1;
          rx_st   <= rx_s ? R_IDLE : R_DATA;
        end
        R_DATA: if (rx_centre) begin
          rx_sh   <= {rx_s, rx_sh[7:1]};
          rx_zero <= rx_zero & !rx_s;
          rx_cnt  <= rx_cnt + 1'b1;
          if (rx_cnt == nbits - 4'd1) rx_st <= par_en ? R_PAR : R_STOP;
        end
        R_PAR: if (rx_centre) begin
          rx_pbit <= rx_s;
          rx_zero <= rx_zero & !rx_s;
          rx_st   <= R_STOP;
        end
        R_STOP: if (rx_centre) begin
          rx_data    <= rx_aligned;
          rx_valid   <= 1'b1;
          frame_err  <= !rx_s;
          break_det  <= rx_brk;
          parity_err <= par_en && !rx_brk && ((^rx_aligned ^ rx_pbit) != !par_even);
          rx_st      <= rx_s ? R_IDLE : R_HOLD;
        end
        default: if (tick && rx_s) rx_st <= R_IDLE;
      endcase
    end
  end

endmodule

module serial_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic loopback,
  input logic send_break,
  input logic tx_wr,
  input logic tx_ready,
  input logic txd,
  input logic rx_valid,
  input logic frame_err,
  input logic break_det
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !send_break && !loopback) |-> txd);

  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_ready) |=> !tx_ready);

  a_r7_loop_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> txd);

  a_r9_break_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (send_break && !loopback) |-> !txd);

  a_r9_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && break_det) |-> frame_err);

endmodule

bind serial_xcvr serial_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .loopback(loopback), .send_break(send_break),
  .tx_wr(tx_wr), .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid),
  .frame_err(frame_err), .break_det(break_det)
);

// File: tb/serial_xcvr_tb.sv
`timescale 1ns/1ps
module serial_xcvr_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd2;
  logic [1:0]  char_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0;
  logic [1:0]  stop_sel = 2'd0;
  logic        loopback = 1'b0, send_break = 1'b0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_valid, parity_err, frame_err, break_det;
  logic        rxd = 1'b1;
  logic        txd;

  int n_checks = 0;
  int n_errors = 0;
  int div_val  = 2;

  always #2 clk = ~clk;

  serial_xcvr #(.DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
    .loopback(loopback), .send_break(send_break), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
    .break_det(break_det), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int n);
    return 8'hFF >> (8 - n);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int n, input bit even);
    return (^(d & mask_of(n))) ^ !even;
  endfunction

  function automatic int stop_ticks(input int sel);
    return (sel >= 2) ? 32 : (sel == 1) ? 24 : 16;
  endfunction

  // R1 R2 R3 R4 R5: decode one transmitted frame at mid-bit
  task automatic tx_frame(input logic [7:0] d, input int n, input bit pe, input bit pev, input int ss);
    int bc = 16 * div_val;
    logic [7:0] got = '0;
    while (!tx_ready) @(posedge clk);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(posedge clk); #1;
    tx_wr = 1'b0;
    check("R2 ready low after write", tx_ready, 0);
    repeat (bc/2) @(posedge clk); #1;
    check("R1 start bit", txd, 0);
    for (int i = 0; i < n; i++) begin
      repeat (bc) @(posedge clk); #1;
      got[i] = txd;
    end
    check("R3 R1 data bits lsb first", got, d & mask_of(n));
    if (pe) begin
      repeat (bc) @(posedge clk); #1;
      check("R4 parity bit", txd, par_of(d, n, pev));
    end
    repeat (bc) @(posedge clk); #1;
    check("R5 stop level", txd, 1);
    repeat (stop_ticks(ss) * div_val - bc/2 - 6) @(posedge clk); #1;
    check("R5 still in stop", tx_ready, 0);
    repeat (12) @(posedge clk); #1;
    check("R5 stop ended", tx_ready, 1);
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (16 * div_val) @(negedge clk);
  endtask

  // R3 R4 R10 R11: drive one frame into rxd and check the result
  task automatic rx_frame(input logic [7:0] d, input int n, input bit pe, input bit pev,
                          input bit flip, input bit bad_stop);
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (pe) drive_bit(par_of(d, n, pev) ^ flip);
    drive_bit(!bad_stop);
    drive_bit(1'b1);
    check("R11 valid after frame", rx_valid, 1);
    check("R3 rx data", rx_data, d & mask_of(n));
    check("R4 parity flag", parity_err, pe && flip);
    check("R10 framing flag", frame_err, bad_stop);
    check("R9 no break", break_det, 0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    check("R11 valid cleared by read", rx_valid, 0);
  endtask

  task automatic set_fmt(input int len, input int pm, input int ss);
    @(negedge clk);
    char_len = 2'(len - 5);
    par_en   = (pm != 0);
    par_even = (pm == 2);
    stop_sel = 2'(ss);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    n_errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle line", txd, 1);
    check("R2 ready at reset", tx_ready, 1);
    check("R11 no char at reset", rx_valid, 0);

    // sweep every format on transmit and receive
    for (int len = 5; len <= 8; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int ss = 0; ss < 3; ss++) begin
          logic [7:0] d = 8'hA5 ^ 8'((len * 37) + (pm * 11) + (ss * 5));
          set_fmt(len, pm, ss);
          tx_frame(d, len, pm != 0, pm == 2, ss);
          rx_frame(~d, len, pm != 0, pm == 2, 1'b0, 1'b0);
        end

    // R4 parity error on every length, both senses
    for (int len = 5; len <= 8; len++)
      for (int pm = 1; pm < 3; pm++) begin
        set_fmt(len, pm, 0);
        rx_frame(8'h3C, len, 1'b1, pm == 2, 1'b1, 1'b0);
      end

    // R10 framing error with nonzero data
    set_fmt(8, 0, 0);
    rx_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);

    // R8 false start glitch of three ticks
    @(negedge clk);
    rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * 32) @(negedge clk);
    check("R8 glitch gives no char", rx_valid, 0);
    rx_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9 external break on rxd
    @(negedge clk);
    rxd = 1'b0;
    repeat (700) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    check("R9 break char valid", rx_valid, 1);
    check("R9 break flag", break_det, 1);
    check("R9 break framing", frame_err, 1);
    check("R9 break parity clear", parity_err, 0);
    check("R9 break data", rx_data, 0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    repeat (64) @(negedge clk);
    check("R9 single char per break", rx_valid, 0);

    // R9 break generation on the pin
    send_break = 1'b1;
    @(negedge clk);
    check("R9 send break pin low", txd, 0);
    send_break = 1'b0;
    @(negedge clk);
    check("R9 pin released", txd, 1);

    // R7 loopback of a character
    set_fmt(7, 2, 1);
    loopback = 1'b1;
    @(negedge clk);
    begin
      int lows = 0;
      tx_wr = 1'b1; tx_data = 8'h6B;
      @(negedge clk);
      tx_wr = 1'b0;
      while (!tx_ready) begin
        if (!txd) lows++;
        @(negedge clk);
      end
      check("R7 pin stays high", lows, 0);
    end
    repeat (32) @(negedge clk);
    check("R7 loopback valid", rx_valid, 1);
    check("R7 loopback data", rx_data, 8'h6B & mask_of(7));
    check("R7 loopback parity ok", parity_err, 0);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;

    // R7 R9 break through loopback, external rxd ignored
    rxd = 1'b1;
    send_break = 1'b1;
    repeat (700) @(negedge clk);
    check("R7 pin high during looped break", txd, 1);
    send_break = 1'b0;
    repeat (64) @(negedge clk);
    check("R9 looped break flag", break_det, 1);
    check("R9 looped break valid", rx_valid, 1);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    loopback = 1'b0;
    repeat (64) @(negedge clk);

    // R6 slower divisor scales the bit time
    div_val = 4;
    divisor = 16'd4;
    set_fmt(8, 1, 2);
    repeat (16) @(negedge clk);
    tx_frame(8'hC3, 8, 1'b1, 1'b0, 2);
    rx_frame(8'h2D, 8, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 divisor four frame done", tx_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule